// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Resolver

This block picks which pending interrupt the processor core should service next and gives the 16-bit address of that source's vector. It takes three groups of inputs:

- two instruction-generated traps (an undefined-opcode trap and a software trap);
- an active-low non-maskable request line;
- fifteen maskable sources: an active-low external line, a periodic tick, three capture channels, five compare channels, a counter overflow, two pulse-accumulator events, a synchronous serial port and an asynchronous serial port.

Each peripheral source is qualified by its own local enable. The two serial ports build their request from several status and enable terms.

The block holds the two processor mask bits. The interrupt mask (I) blocks every maskable source. The non-maskable mask (X) blocks the non-maskable line. Both bits are one after reset. Software rewrites them through a write strobe. A write may clear X but can never set it again, so once the non-maskable line is enabled it stays enabled.

The winning request and its vector are registered and re-resolved on every clock. The output therefore always shows the highest source pending one cycle earlier, until the core takes it.

Top module: `irq_vector_resolver`

## Requirements
- R1: While `rst_n` is low, and after it is released, `imask` and `nmask` read 1, `req_valid` reads 0 and `req_vector` reads 0x0000.
- R2: A clock edge with `mask_wr`=1 loads `imask` from `mask_wr_i`. It clears `nmask` when `mask_wr_x` is 0 and leaves `nmask` unchanged when `mask_wr_x` is 1, so `nmask` never returns to 1 after it has been cleared.
- R3: When `nmask`=0 and `nmi_n`=0, and no trap is present, the request is valid with vector 0xFFF4, whatever maskable sources are pending. When `nmask`=1, `nmi_n` has no effect.
- R4: The maskable sources, numbered k, are in descending priority: k=0 external line (`ext_irq_n` low), k=1 periodic tick, k=2..4 capture channels 0..2 (bit i of `cap_*`), k=5..9 compare channels 0..4 (bit i of `cmp_*`), k=10 counter overflow, k=11 accumulator overflow, k=12 accumulator edge, k=13 synchronous serial, k=14 asynchronous serial. Source k uses vector 0xFFF2 − 2k, and the lowest pending k wins.
- R5: The periodic, capture, compare, overflow and accumulator sources request only when both their flag and their enable are 1.
- R6: The synchronous serial source requests when (`spi_done` OR `spi_fault`) AND `spi_ie`.
- R7: The asynchronous serial source requests when any one of these terms holds:
  - (`uart_rx_full` OR `uart_rx_ovr`) AND `uart_rx_ie` AND `uart_rx_on`;
  - `uart_tx_empty` AND `uart_tx_ie` AND `uart_tx_on`;
  - `uart_tx_done` AND `uart_txdone_ie` AND `uart_tx_on`;
  - `uart_rx_idle` AND `uart_idle_ie` AND `uart_rx_on`.
- R8: While `imask`=1, no maskable source produces a request.
- R9: `bad_op`=1 gives vector 0xFFF8. Otherwise `sw_trap`=1 gives vector 0xFFF6. Both traps outrank all other sources and are unaffected by `imask` and `nmask`.
- R10: The outputs change only at a clock edge and reflect the inputs and mask bits present at that edge. When nothing qualifies, `req_valid`=0 and `req_vector`=0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr | input | 1 | Mask write strobe |
| mask_wr_i | input | 1 | New value of the interrupt mask |
| mask_wr_x | input | 1 | New value of the non-maskable mask (only 0 takes effect) |
| bad_op | input | 1 | Undefined-opcode trap |
| sw_trap | input | 1 | Software trap |
| nmi_n | input | 1 | Non-maskable request, active low |
| ext_irq_n | input | 1 | External maskable request, active low, level |
| rtc_flag | input | 1 | Periodic tick flag |
| rtc_en | input | 1 | Periodic tick enable |
| cap_flag | input | NUM_IC | Capture flags |
| cap_en | input | NUM_IC | Capture enables |
| cmp_flag | input | NUM_OC | Compare flags |
| cmp_en | input | NUM_OC | Compare enables |
| ovf_flag | input | 1 | Counter overflow flag |
| ovf_en | input | 1 | Counter overflow enable |
| acc_ovf_flag | input | 1 | Accumulator overflow flag |
| acc_ovf_en | input | 1 | Accumulator overflow enable |
| acc_edge_flag | input | 1 | Accumulator input edge flag |
| acc_edge_en | input | 1 | Accumulator input edge enable |
| spi_done | input | 1 | Synchronous serial transfer complete |
| spi_fault | input | 1 | Synchronous serial mode fault |
| spi_ie | input | 1 | Synchronous serial interrupt enable |
| uart_rx_full | input | 1 | Receive data ready |
| uart_rx_ovr | input | 1 | Receive overrun |
| uart_tx_empty | input | 1 | Transmit holding register empty |
| uart_tx_done | input | 1 | Transmission complete |
| uart_rx_idle | input | 1 | Receive line idle |
| uart_rx_ie | input | 1 | Receive interrupt enable |
| uart_tx_ie | input | 1 | Transmit-empty interrupt enable |
| uart_txdone_ie | input | 1 | Transmit-complete interrupt enable |
| uart_idle_ie | input | 1 | Idle interrupt enable |
| uart_tx_on | input | 1 | Transmitter enabled |
| uart_rx_on | input | 1 | Receiver enabled |
| imask | output | 1 | Interrupt mask bit |
| nmask | output | 1 | Non-maskable mask bit |
| req_valid | output | 1 | A request is present |
| req_vector | output | VEC_W | Vector address of the winning source |

## Verification
Some behaviours are checked by assertions on every cycle:

- the non-maskable mask never returning to one;
- the interrupt mask silencing all maskable sources;
- the trap and non-maskable vectors appearing one cycle after their conditions;
- the external line's vector;
- the idle state when nothing is pending.

Other behaviours only the bench's sweeps can show. These are the full maskable priority order over every pair of sources and the per-source flag-and-enable qualification. They also include the exhaustive truth tables of both serial-port request terms and the reset state. The last is the output holding its value between clock edges.

// File: rtl/irq_vector_resolver.sv
module irq_vector_resolver #(
  parameter int VEC_W  = 16,
  parameter int NUM_IC = 3,
  parameter int NUM_OC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic              mask_wr_i,
  input  logic              mask_wr_x,
  input  logic              bad_op,
  input  logic              sw_trap,
  input  logic              nmi_n,
  input  logic              ext_irq_n,
  input  logic              rtc_flag,
  input  logic              rtc_en,
  input  logic [NUM_IC-1:0] cap_flag,
  input  logic [NUM_IC-1:0] cap_en,
  input  logic [NUM_OC-1:0] cmp_flag,
  input  logic [NUM_OC-1:0] cmp_en,
  input  logic              ovf_flag,
  input  logic              ovf_en,
  input  logic              acc_ovf_flag,
  input  logic              acc_ovf_en,
  input  logic              acc_edge_flag,
  input  logic              acc_edge_en,
  input  logic              spi_done,
  input  logic              spi_fault,
  input  logic              spi_ie,
  input  logic              uart_rx_full,
  input  logic              uart_rx_ovr,
  input  logic              uart_tx_empty,
  input  logic              uart_tx_done,
  input  logic              uart_rx_idle,
  input  logic              uart_rx_ie,
  input  logic              uart_tx_ie,
  input  logic              uart_txdone_ie,
  input  logic              uart_idle_ie,
  input  logic              uart_tx_on,
  input  logic              uart_rx_on,
  output logic              imask,
  output logic              nmask,
  output logic              req_valid,
  output logic [VEC_W-1:0]  req_vector
);

  localparam int NUM_MSK = 7 + NUM_IC + NUM_OC;
  localparam int IDX_W   = $clog2(NUM_MSK);
  localparam int CAP_LO  = 2;
  localparam int CMP_LO  = CAP_LO + NUM_IC;
  localparam int TAIL_LO = CMP_LO + NUM_OC;
  localparam logic [VEC_W-1:0] VEC_TOP   = {VEC_W{1'b1}};
  localparam logic [VEC_W-1:0] VEC_ILLOP = VEC_TOP - VEC_W'(7);
  localparam logic [VEC_W-1:0] VEC_SWI   = VEC_TOP - VEC_W'(9);
  localparam logic [VEC_W-1:0] VEC_NMI   = VEC_TOP - VEC_W'(11);
  localparam logic [VEC_W-1:0] VEC_BASE  = VEC_TOP - VEC_W'(13);

  // Mask bits: I follows writes, X may only be cleared.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask <= 1'b1;
      nmask <= 1'b1;
    end else if (mask_wr) begin
      imask <= mask_wr_i;
      nmask <= nmask & mask_wr_x;
    end
  end

  logic [NUM_MSK-1:0] src;
  logic spi_req, uart_req, nmi_live;

  assign nmi_live = !nmask && !nmi_n;
  assign spi_req  = (spi_done | spi_fault) & spi_ie;
  assign uart_req = ((uart_rx_full | uart_rx_ovr) & uart_rx_ie & uart_rx_on)
                  | (uart_tx_empty & uart_tx_ie & uart_tx_on)
                  | (uart_tx_done & uart_txdone_ie & uart_tx_on)
                  | (uart_rx_idle & uart_idle_ie & uart_rx_on);

  assign src[0] = !ext_irq_n;
  assign src[1] = rtc_flag & rtc_en;

  for (genvar i = 0; i < NUM_IC; i++) begin : g_cap
    assign src[CAP_LO+i] = cap_flag[i] & cap_en[i];
  end

  for (genvar i = 0; i < NUM_OC; i++) begin : g_cmp
    assign src[CMP_LO+i] = cmp_flag[i] & cmp_en[i];
  end

  assign src[TAIL_LO]   = ovf_flag & ovf_en;
  assign src[TAIL_LO+1] = acc_ovf_flag & acc_ovf_en;
  assign src[TAIL_LO+2] = acc_edge_flag & acc_edge_en;
  assign src[TAIL_LO+3] = spi_req;
  assign src[TAIL_LO+4] = uart_req;

  logic             msk_hit;
  logic [IDX_W-1:0] msk_idx;

  always_comb begin
    msk_hit = 1'b0;
    msk_idx = '0;
    for (int k = NUM_MSK - 1; k >= 0; k--) begin
      if (src[k]) begin
        msk_hit = 1'b1;
        msk_idx = IDX_W'(k);
      end
    end
  end

  logic             nxt_valid;
  logic [VEC_W-1:0] nxt_vector;

  always_comb begin
    nxt_valid  = 1'b1;
    nxt_vector = '0;
    if (bad_op)                nxt_vector = VEC_ILLOP;
    else if (sw_trap)          nxt_vector = VEC_SWI;
    else if (nmi_live)         nxt_vector = VEC_NMI;
    else if (!imask && msk_hit) nxt_vector = VEC_BASE - (VEC_W'(msk_idx) << 1);
    else                       nxt_valid  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_vector <= '0;
    end else begin
      req_valid  <= nxt_valid;
      req_vector <= nxt_vector;
    end
  end

  // R2
  nmask_oneway_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nmask |=> !nmask);

  // R8
  imask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imask && !bad_op && !sw_trap && (nmask || nmi_n)) |=> !req_valid);

  // R3
  nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad_op && !sw_trap && !nmask && !nmi_n) |=> (req_valid && req_vector == VEC_NMI));

  // R9
  illop_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |=> (req_valid && req_vector == VEC_ILLOP));

  // R9
  swi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad_op && sw_trap) |=> (req_valid && req_vector == VEC_SWI));

  // R4
  ext_irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad_op && !sw_trap && (nmask || nmi_n) && !imask && !ext_irq_n)
      |=> (req_valid && req_vector == VEC_BASE));

  // R10
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad_op && !sw_trap && (nmask || nmi_n) && (src == '0))
      |=> (!req_valid && req_vector == '0));

endmodule

// File: tb/tb_irq_vector_resolver.sv
`timescale 1ns/1ps
module tb_irq_vector_resolver;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mask_wr = 0, mask_wr_i = 0, mask_wr_x = 0;
  logic bad_op, sw_trap, nmi_n, ext_irq_n, rtc_flag, rtc_en;
  logic [2:0] cap_flag, cap_en;
  logic [4:0] cmp_flag, cmp_en;
  logic ovf_flag, ovf_en, acc_ovf_flag, acc_ovf_en, acc_edge_flag, acc_edge_en;
  logic spi_done, spi_fault, spi_ie;
  logic uart_rx_full, uart_rx_ovr, uart_tx_empty, uart_tx_done, uart_rx_idle;
  logic uart_rx_ie, uart_tx_ie, uart_txdone_ie, uart_idle_ie, uart_tx_on, uart_rx_on;
  logic imask, nmask, req_valid;
  logic [15:0] req_vector;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_resolver dut (.*);

  task automatic clear_all();
    bad_op = 0; sw_trap = 0; nmi_n = 1; ext_irq_n = 1; rtc_flag = 0; rtc_en = 0;
    cap_flag = 0; cap_en = 0; cmp_flag = 0; cmp_en = 0;
    ovf_flag = 0; ovf_en = 0; acc_ovf_flag = 0; acc_ovf_en = 0;
    acc_edge_flag = 0; acc_edge_en = 0; spi_done = 0; spi_fault = 0; spi_ie = 0;
    uart_rx_full = 0; uart_rx_ovr = 0; uart_tx_empty = 0; uart_tx_done = 0;
    uart_rx_idle = 0; uart_rx_ie = 0; uart_tx_ie = 0; uart_txdone_ie = 0;
    uart_idle_ie = 0; uart_tx_on = 0; uart_rx_on = 0;
  endtask

  task automatic set_src(int k, bit with_en);
    case (k)
      0: ext_irq_n = 0;
      1: begin rtc_flag = 1; rtc_en = with_en; end
      2, 3, 4: begin cap_flag[k-2] = 1; cap_en[k-2] = with_en; end
      5, 6, 7, 8, 9: begin cmp_flag[k-5] = 1; cmp_en[k-5] = with_en; end
      10: begin ovf_flag = 1; ovf_en = with_en; end
      11: begin acc_ovf_flag = 1; acc_ovf_en = with_en; end
      12: begin acc_edge_flag = 1; acc_edge_en = with_en; end
      13: begin spi_done = 1; spi_ie = with_en; end
      default: begin uart_rx_full = 1; uart_rx_ie = with_en; uart_rx_on = 1; end
    endcase
  endtask

  function automatic logic [15:0] vec_of(int k);
    return 16'hFFF2 - 16'(2 * k);
  endfunction

  task automatic cmp_out(string tag, logic ev, logic [15:0] evec);
    checks++;
    if (req_valid !== ev || req_vector !== evec) begin
      errors++;
      $display("FAIL %s: valid=%b vec=%h expected valid=%b vec=%h",
               tag, req_valid, req_vector, ev, evec);
    end
  endtask

  task automatic step_check(string tag, logic ev, logic [15:0] evec);
    @(posedge clk); @(negedge clk);
    cmp_out(tag, ev, evec);
  endtask

  task automatic cmp_mask(string tag, logic ei, logic ex);
    checks++;
    if (imask !== ei || nmask !== ex) begin
      errors++;
      $display("FAIL %s: imask=%b nmask=%b expected imask=%b nmask=%b",
               tag, imask, nmask, ei, ex);
    end
  endtask

  task automatic write_mask(logic wi, logic wx);
    mask_wr = 1; mask_wr_i = wi; mask_wr_x = wx;
    @(posedge clk); @(negedge clk);
    mask_wr = 0;
  endtask

  task automatic all_maskable();
    for (int k = 0; k < 15; k++) set_src(k, 1);
  endtask

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    cmp_out("R1 reset outputs", 1'b0, 16'h0000);
    cmp_mask("R1 reset masks", 1'b1, 1'b1);
    rst_n = 1;
    @(negedge clk);
    cmp_mask("R1 masks after release", 1'b1, 1'b1);
    step_check("R1 idle after release", 1'b0, 16'h0000);

    all_maskable();
    step_check("R8 imask blocks all", 1'b0, 16'h0000);
    nmi_n = 0;
    step_check("R3 nmi ignored while nmask set", 1'b0, 16'h0000);
    clear_all();

    write_mask(1'b0, 1'b1);
    cmp_mask("R2 write I=0 X=1", 1'b0, 1'b1);

    for (int k = 0; k < 15; k++) begin
      clear_all(); set_src(k, 1);
      step_check($sformatf("R4 single source %0d", k), 1'b1, vec_of(k));
    end
    for (int k = 1; k < 13; k++) begin
      clear_all(); set_src(k, 0);
      step_check($sformatf("R5 flag without enable %0d", k), 1'b0, 16'h0000);
    end
    for (int a = 0; a < 15; a++) begin
      for (int b = a + 1; b < 15; b++) begin
        clear_all(); set_src(a, 1); set_src(b, 1);
        step_check($sformatf("R4 pair %0d,%0d", a, b), 1'b1, vec_of(a));
      end
    end

    for (int v = 0; v < 8; v++) begin
      clear_all();
      {spi_done, spi_fault, spi_ie} = 3'(v);
      step_check($sformatf("R6 spi combo %0d", v), ((v[2] | v[1]) & v[0]),
                 ((v[2] | v[1]) & v[0]) ? 16'hFFD8 : 16'h0000);
    end

    for (int v = 0; v < 2048; v++) begin
      logic e;
      clear_all();
      {uart_rx_full, uart_rx_ovr, uart_tx_empty, uart_tx_done, uart_rx_idle,
       uart_rx_ie, uart_tx_ie, uart_txdone_ie, uart_idle_ie, uart_tx_on, uart_rx_on} = 11'(v);
      e = ((v[10] | v[9]) & v[5] & v[0]) | (v[8] & v[4] & v[1])
        | (v[7] & v[3] & v[1]) | (v[6] & v[2] & v[0]);
      step_check($sformatf("R7 uart combo %0d", v), e, e ? 16'hFFD6 : 16'h0000);
    end

    clear_all();
    write_mask(1'b0, 1'b0);
    cmp_mask("R2 clear X", 1'b0, 1'b0);
    all_maskable(); nmi_n = 0;
    step_check("R3 nmi over all maskable", 1'b1, 16'hFFF4);
    write_mask(1'b0, 1'b1);
    cmp_mask("R2 X stays clear after write of 1", 1'b0, 1'b0);
    step_check("R2 nmi still live", 1'b1, 16'hFFF4);
    nmi_n = 1;
    step_check("R3 nmi released", 1'b1, 16'hFFF2);

    nmi_n = 0; bad_op = 1;
    step_check("R9 illop over nmi", 1'b1, 16'hFFF8);
    bad_op = 0; sw_trap = 1;
    step_check("R9 swi over nmi", 1'b1, 16'hFFF6);
    bad_op = 1;
    step_check("R9 illop over swi", 1'b1, 16'hFFF8);
    clear_all();
    write_mask(1'b1, 1'b1);
    cmp_mask("R2 I set again", 1'b1, 1'b0);
    sw_trap = 1;
    step_check("R9 swi with imask set", 1'b1, 16'hFFF6);
    clear_all(); bad_op = 1;
    step_check("R9 illop with imask set", 1'b1, 16'hFFF8);

    clear_all();
    write_mask(1'b0, 1'b1);
    set_src(7, 1);
    step_check("R10 follows source 7", 1'b1, vec_of(7));
    set_src(2, 1);
    #1 cmp_out("R10 holds until edge", 1'b1, vec_of(7));
    step_check("R10 follows higher source 2", 1'b1, vec_of(2));
    clear_all();
    step_check("R10 idle when none", 1'b0, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule